// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This purely combinational block answers one question for a local interrupt controller: is it a target of a given inter-processor message? It takes the controller's own identity registers and the routing fields of the message, and returns one match bit. An error bit flags a logical-mode lookup made while the format register holds a value the block does not recognise.

The routing has two levels. The 2-bit shorthand comes first: it can name the sender alone, every unit, or every unit but the sender. When the shorthand is zero, the destination field is used. In physical mode that field is an ID, and 0xFF acts as broadcast. In logical mode the field is compared against the logical destination register. That comparison is a flat bitmask, a cluster match, or, when the extended-mode flag is set, a full-width bitmask.

Top module: `ipi_dest_match`

## Requirements
- R1: With shorthand 1 (self only), `hit` equals `from_self`.
- R2: With shorthand 2 (all including self), `hit` is 1 whatever the other inputs are.
- R3: With shorthand 3 (all excluding self), `hit` equals the inverse of `from_self`.
- R4: With shorthand 0 and `dst_logical` = 0 (physical), `hit` is 1 exactly when `dst_id[7:0]` is 0xFF or equals `id_reg[31:24]`. Bits 31:8 of `dst_id` have no effect.
- R5: With shorthand 0, `dst_logical` = 1, `ext_mode` = 0 and `fmt_reg[31:28]` = 0xF (flat), `hit` is 1 exactly when `ldr_reg[31:24] & dst_id[7:0]` is nonzero.
- R6: In the same case with `fmt_reg[31:28]` = 0x0 (cluster), `hit` is 1 exactly when `ldr_reg[31:28]` equals `dst_id[7:4]` and `ldr_reg[27:24] & dst_id[3:0]` is nonzero.
- R7: With shorthand 0, `dst_logical` = 1 and `ext_mode` = 1, `hit` is 1 exactly when `ldr_reg & dst_id` (all 32 bits) is nonzero. `fmt_reg` has no effect.
- R8: With shorthand 0, `dst_logical` = 1, `ext_mode` = 0 and `fmt_reg[31:28]` neither 0xF nor 0x0, `hit` is 0 and `fmt_err` is 1. In every other case `fmt_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_reg | input | 32 | Local ID register; the ID sits in bits 31:24 |
| ldr_reg | input | 32 | Logical destination register |
| fmt_reg | input | 32 | Destination format register; bits 31:28 select the model |
| ext_mode | input | 1 | Extended addressing mode enable |
| from_self | input | 1 | The message originates from this unit |
| shorthand | input | 2 | 0 dest field, 1 self, 2 all incl. self, 3 all excl. self |
| dst_logical | input | 1 | 1 selects logical destination mode, 0 physical |
| dst_id | input | 32 | Destination field of the message |
| hit | output | 1 | This unit is a target |
| fmt_err | output | 1 | Logical lookup with an unknown format value |

## Verification
The block holds no state, so any fault is a wrong decision that shows on `hit` or `fmt_err` in the same cycle as the inputs that expose it. A fault in cluster decoding shows only when the format nibble is 0x0 and the upper nibbles agree. A fault that swaps the bitmask width between flat and extended mode shows only when the overlap lies in the bits that one width covers and the other does not. The stimulus therefore steers destination values onto the local ID, onto broadcast and onto matching cluster nibbles. It also walks the format nibble through recognised and unrecognised values, so each branch is reached many times.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;

    typedef enum logic [1:0] {
        SH_DEST    = 2'd0,
        SH_SELF    = 2'd1,
        SH_ALL_INC = 2'd2,
        SH_ALL_EXC = 2'd3
    } shorthand_e;

    localparam int FMT_W = 4;
    localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

endpackage

// File: rtl/dm_phys_match.sv
module dm_phys_match #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] own_id,
    input  logic [ID_W-1:0] target,
    output logic            phys_hit
);
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    always_comb begin
        phys_hit = (target == BCAST) || (target == own_id);
    end
endmodule

// File: rtl/dm_logic_match.sv
module dm_logic_match
    import ipi_dest_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int ID_W  = 8
) (
    input  logic [REG_W-1:0] ldr_full,
    input  logic [FMT_W-1:0] fmt_sel,
    input  logic             ext_mode,
    input  logic [REG_W-1:0] target,
    output logic             log_hit,
    output logic             bad_fmt
);
    localparam int NIB_W  = ID_W / 2;
    localparam int ID_LSB = REG_W - ID_W;

    logic [ID_W-1:0]  lid;
    logic [ID_W-1:0]  tid;
    logic [NIB_W-1:0] member_ov;
    logic             flat_hit;
    logic             clus_hit;
    logic             wide_hit;

    assign lid = ldr_full[REG_W-1:ID_LSB];
    assign tid = target[ID_W-1:0];

    for (genvar b = 0; b < NIB_W; b++) begin : g_member
        assign member_ov[b] = lid[b] & tid[b];
    end

    always_comb begin
        flat_hit = |(lid & tid);
        clus_hit = (lid[ID_W-1:NIB_W] == tid[ID_W-1:NIB_W]) && (|member_ov);
        wide_hit = |(ldr_full & target);
    end

    always_comb begin
        log_hit = 1'b0;
        bad_fmt = 1'b0;
        if (ext_mode) begin
            log_hit = wide_hit;
        end else begin
            unique case (fmt_sel)
                FMT_FLAT:    log_hit = flat_hit;
                FMT_CLUSTER: log_hit = clus_hit;
                default:     bad_fmt = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import ipi_dest_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int ID_W  = 8
) (
    input  logic [REG_W-1:0] id_reg,
    input  logic [REG_W-1:0] ldr_reg,
    input  logic [REG_W-1:0] fmt_reg,
    input  logic             ext_mode,
    input  logic             from_self,
    input  logic [1:0]       shorthand,
    input  logic             dst_logical,
    input  logic [REG_W-1:0] dst_id,
    output logic             hit,
    output logic             fmt_err
);
    localparam int ID_LSB = REG_W - ID_W;

    logic p_hit;
    logic l_hit;
    logic l_bad;
    shorthand_e sh;

    assign sh = shorthand_e'(shorthand);

    dm_phys_match #(.ID_W(ID_W)) u_phys (
        .own_id   (id_reg[REG_W-1:ID_LSB]),
        .target   (dst_id[ID_W-1:0]),
        .phys_hit (p_hit)
    );

    dm_logic_match #(.REG_W(REG_W), .ID_W(ID_W)) u_logic (
        .ldr_full (ldr_reg),
        .fmt_sel  (fmt_reg[REG_W-1:REG_W-FMT_W]),
        .ext_mode (ext_mode),
        .target   (dst_id),
        .log_hit  (l_hit),
        .bad_fmt  (l_bad)
    );

    always_comb begin
        hit     = 1'b0;
        fmt_err = 1'b0;
        unique case (sh)
            SH_SELF:    hit = from_self;
            SH_ALL_INC: hit = 1'b1;
            SH_ALL_EXC: hit = !from_self;
            SH_DEST: begin
                if (dst_logical) begin
                    hit     = l_hit;
                    fmt_err = l_bad;
                end else begin
                    hit = p_hit;
                end
            end
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        // R2
        all_inc_chk: assert (!(shorthand == 2'd2) || hit);
        // R3
        all_exc_chk: assert (!(shorthand == 2'd3) || (hit != from_self));
        // R4
        bcast_chk: assert (!(shorthand == 2'd0 && !dst_logical && dst_id[ID_W-1:0] == {ID_W{1'b1}}) || hit);
        // R8
        err_nohit_chk: assert (!fmt_err || (!hit && shorthand == 2'd0 && dst_logical && !ext_mode));
        // R6
        cluster_chk: assert (!(shorthand == 2'd0 && dst_logical && !ext_mode
                              && fmt_reg[REG_W-1:REG_W-FMT_W] == FMT_CLUSTER && hit)
                             || (ldr_reg[REG_W-1:REG_W-ID_W/2] == dst_id[ID_W-1:ID_W/2]));
    end
endmodule

// File: tb/ipi_dest_match_test.sv
module ipi_dest_match_test;
    logic        clk = 1'b0;
    logic [31:0] id_reg, ldr_reg, fmt_reg, dst_id;
    logic        ext_mode, from_self, dst_logical;
    logic [1:0]  shorthand;
    logic        hit, fmt_err;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ipi_dest_match uut (
        .id_reg(id_reg), .ldr_reg(ldr_reg), .fmt_reg(fmt_reg),
        .ext_mode(ext_mode), .from_self(from_self), .shorthand(shorthand),
        .dst_logical(dst_logical), .dst_id(dst_id),
        .hit(hit), .fmt_err(fmt_err)
    );

    task automatic model(output bit m, output bit e, output string tag);
        int up_l, up_d, lo_l, lo_d, lid, d8;
        m = 0; e = 0; tag = "";
        lid = int'(ldr_reg >> 24);
        d8  = int'(dst_id % 256);
        if (shorthand == 1) begin m = from_self; tag = "R1"; end
        else if (shorthand == 2) begin m = 1; tag = "R2"; end
        else if (shorthand == 3) begin m = !from_self; tag = "R3"; end
        else if (!dst_logical) begin
            m = (d8 == 255) || (d8 == int'(id_reg >> 24)); tag = "R4";
        end else if (ext_mode) begin
            m = ((ldr_reg & dst_id) != 0); tag = "R7";
        end else if ((fmt_reg >> 28) == 15) begin
            m = ((lid & d8) != 0); tag = "R5";
        end else if ((fmt_reg >> 28) == 0) begin
            up_l = lid / 16; up_d = d8 / 16; lo_l = lid % 16; lo_d = d8 % 16;
            m = (up_l == up_d) && ((lo_l & lo_d) != 0); tag = "R6";
        end else begin
            e = 1; tag = "R8";
        end
    endtask

    task automatic compare();
        bit m, e;
        string tag;
        model(m, e, tag);
        checks++;
        if (hit !== m || fmt_err !== e) begin
            fails++;
            $display("FAIL %s: hit=%0b fmt_err=%0b expected hit=%0b fmt_err=%0b",
                     tag, hit, fmt_err, m, e);
        end
    endtask

    task automatic apply(input logic [31:0] i, l, f, d, input logic x, s, lg,
                         input logic [1:0] sh);
        @(posedge clk);
        id_reg = i; ldr_reg = l; fmt_reg = f; dst_id = d;
        ext_mode = x; from_self = s; dst_logical = lg; shorthand = sh;
        @(negedge clk);
        compare();
    endtask

    initial begin
        id_reg = 0; ldr_reg = 0; fmt_reg = 32'hFFFF_FFFF; dst_id = 0;
        ext_mode = 0; from_self = 0; dst_logical = 0; shorthand = 0;
        @(negedge clk);
        compare();  // initial state, R4 path
        // R1 self only
        apply(32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h05, 0, 1, 0, 2'd1);
        apply(32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h05, 0, 0, 0, 2'd1);
        // R2 all including self
        apply(0, 0, 32'h1000_0000, 0, 0, 1, 1, 2'd2);
        // R3 all excluding self
        apply(0, 0, 0, 32'hFF, 0, 1, 0, 2'd3);
        apply(0, 0, 0, 0, 0, 0, 0, 2'd3);
        // R4 physical: equal, broadcast, upper bits ignored, miss
        apply(32'h2A00_0000, 0, 0, 32'hFFFF_FF2A, 0, 0, 0, 2'd0);
        apply(32'h2A00_0000, 0, 0, 32'h0000_00FF, 0, 0, 0, 2'd0);
        apply(32'h2A00_0000, 0, 0, 32'h0000_002B, 0, 1, 0, 2'd0);
        // R5 flat
        apply(0, 32'h8000_0000, 32'hF000_0000, 32'h80, 0, 0, 1, 2'd0);
        apply(0, 32'h8000_0000, 32'hF000_0000, 32'h7F, 0, 0, 1, 2'd0);
        // R6 cluster: overlap same cluster, overlap other cluster, no overlap
        apply(0, 32'h3500_0000, 32'h0FFF_FFFF, 32'h34, 0, 0, 1, 2'd0);
        apply(0, 32'h3500_0000, 32'h0FFF_FFFF, 32'h45, 0, 0, 1, 2'd0);
        apply(0, 32'h3500_0000, 32'h0FFF_FFFF, 32'h3A, 0, 0, 1, 2'd0);
        // R7 extended: low-bit overlap only, format ignored
        apply(0, 32'h0001_0000, 32'h5000_0000, 32'h0001_0000, 1, 0, 1, 2'd0);
        apply(0, 32'hFF00_0000, 32'hF000_0000, 32'h00FF_FFFF, 1, 0, 1, 2'd0);
        // R8 unknown format
        apply(0, 32'hFF00_0000, 32'h7000_0000, 32'hFF, 0, 0, 1, 2'd0);
        apply(0, 32'hFF00_0000, 32'h7000_0000, 32'hFF, 1, 0, 1, 2'd0);
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] i, l, f, d;
            int k;
            i = $urandom; l = $urandom; d = $urandom;
            k = $urandom_range(0, 3);
            f = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0FFF_FFFF : $urandom;
            k = $urandom_range(0, 5);
            if (k == 0) d[7:0] = i[31:24];
            else if (k == 1) d[7:0] = 8'hFF;
            else if (k == 2) d[7:4] = l[31:28];
            apply(i, l, f, d, 1'($urandom), 1'($urandom), 1'($urandom),
                  2'($urandom_range(0, 3)));
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule